// File: doc/BRIEF.md
# Linked Free-Sector List Allocator

This block hands out and takes back 256-byte storage sectors of a compressed main-memory region. The free pool is a singly linked list whose nodes are free sectors themselves: a node holds 63 free-sector pointers and one pointer to the next node. The list therefore needs no storage of its own. Nodes are consumed when the pool shrinks and created again when it grows.

The block keeps up to two nodes' worth of pointers (128 entries) in an on-chip ring that works as a stack. The client sends one request per handshake. An allocate request takes one to four sectors. A free request returns one sector. When fewer than four pointers remain on chip and a node is still waiting in memory, the block fetches that node over a 16-byte-word memory port. The node's 63 pointers and the node's own sector then join the bottom of the ring. When the ring is full, the 64 oldest entries are written out as a new list node and become the new list head. Through all of this the free pool behaves as one last-in-first-out stack. The block also tracks the number of free sectors, drives two sectors-used alarms, refuses requests it cannot honour, and flags corrupted or out-of-range list entries read back from memory.

Top module: `free_list_alloc`

## Requirements
- R1: Synchronous reset loads the list head from `cfg_head` and the node count from `cfg_nodes`. After reset `free_count` equals 64 × `cfg_nodes`, `rsp_valid` and `mem_req` are 0, and no pointer is held on chip. When `cfg_nodes` is not zero, `req_ready` is therefore 0 until the first node is fetched.
- R2: An allocate request is `req_free`=0 with `req_num`=n−1, where n is 1 to 4. It is accepted on a clock edge where `req_valid` and `req_ready` are both 1. One cycle later `rsp_valid`=1 and `rsp_err`=0. Lane i of `rsp_ptrs` (bits 24i+23:24i) carries the i-th most recently freed entry of the pool, which acts as one LIFO stack. Lanes i ≥ n are zero.
- R3: A free request (`req_free`=1) with `req_ptr` inside [`cfg_lo`, `cfg_hi`] answers with `rsp_err`=0. That pointer becomes the next one allocated.
- R4: A free request with `req_ptr` outside [`cfg_lo`, `cfg_hi`] answers with `rsp_err`=1. Neither the pool nor `free_count` changes.
- R5: An allocate request for more sectors than `free_count` answers with `rsp_err`=1 and removes nothing.
- R6: Refill starts when fewer than 4 pointers are on chip and at least one node is in memory. `req_ready` drops and 16 reads are issued at word addresses {node, w}, with w rising from 0 to 15. The node's 63 pointers, and then its own sector below them, go to the bottom of the pool, so the LIFO order is kept. The node's next pointer becomes the new head.
- R7: Spill starts when 128 pointers are on chip. The oldest of them becomes the node address. The next 63 oldest, in order, fill entries 0..62, and entry 63 holds the previous head. The node goes out in 16 writes. In each word, lane k (bits 32k+31:32k) of word w holds entry 4w+k. An entry holds the pointer in bits 23:0, the XOR of bits 23:0 in bit 24, and zero in bits 31:25. A later refill returns these entries in their original order.
- R8: `free_count` always equals the number of free sectors in the pool. It changes only on the edge that accepts a request.
- R9: `alarm[t]` is 1 when (`cfg_hi`−`cfg_lo`+1−`free_count`) > `thr[t]`. `thr[t]` sits at bits 25t+24:25t. The alarm updates on the same edge as `free_count`.
- R10: `rd_fault` pulses for one cycle after a fetched word that contains any of the following: an entry whose bit 24 does not match its parity, an entry with nonzero bits 31:25, or a slot pointer outside the range. A next-node pointer is range-checked only when another node follows it.
- R11: `mem_req` holds its address, direction and write data until `mem_ready` is 1. Read data is taken in the cycle where `mem_rvalid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_head | input | 24 | first list node at reset |
| cfg_nodes | input | 25 | number of list nodes in memory at reset |
| cfg_lo | input | 24 | lowest valid sector index |
| cfg_hi | input | 24 | highest valid sector index |
| thr | input | 50 | two sectors-used thresholds, 25 bits each |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request can be taken this cycle |
| req_free | input | 1 | 1 = free one sector, 0 = allocate |
| req_num | input | 2 | sectors to allocate minus one |
| req_ptr | input | 24 | sector to free |
| rsp_valid | output | 1 | response present |
| rsp_err | output | 1 | request refused |
| rsp_ptrs | output | 96 | allocated sectors, four 24-bit lanes |
| free_count | output | 25 | free sectors in the pool |
| alarm | output | 2 | sectors-used alarms |
| rd_fault | output | 1 | corrupted or out-of-range entry fetched |
| mem_req | output | 1 | memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 28 | word address {sector, word} |
| mem_wdata | output | 128 | write data |
| mem_ready | input | 1 | memory takes the request |
| mem_rvalid | input | 1 | read data present |
| mem_rdata | input | 128 | read data |

## Verification
A request accepted on a rising edge changes `free_count` and `alarm` on that same edge. Its response appears on `rsp_valid`, `rsp_err` and `rsp_ptrs` from that edge until the next one. `rd_fault` follows the edge that consumed the faulty read word by one cycle. The bench drives and samples on falling edges, so every value it reads is the one registered by the preceding rising edge. Its LIFO model updates at the accepting edge, so the refill and spill phases never shift an expected value. Allocation order, after several refills and one spill, is compared against a queue that never knows where the pointers are held.

// File: rtl/falloc_pkg.sv
package falloc_pkg;
  // width of one list entry inside a 16-byte memory word
  localparam int ENT_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_SPILL
  } fl_state_t;
endpackage

// File: rtl/falloc_ring.sv
module falloc_ring #(
  parameter int PTR_W = 24,
  parameter int DEPTH = 128,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic [LANES-1:0]       wr_en,
  input  logic [LANES*$clog2(DEPTH)-1:0] wr_idx,
  input  logic [LANES*PTR_W-1:0] wr_data,
  input  logic [LANES*$clog2(DEPTH)-1:0] rd_idx,
  output logic [LANES*PTR_W-1:0] rd_data
);
  localparam int IW = $clog2(DEPTH);

  logic [PTR_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_en[i]) store[wr_idx[i*IW +: IW]] <= wr_data[i*PTR_W +: PTR_W];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rd
    assign rd_data[i*PTR_W +: PTR_W] = store[rd_idx[i*IW +: IW]];
  end

  // two write lanes never aim at the same slot in one cycle (R6)
  always @(posedge clk) begin
    for (int a = 0; a < LANES; a++) begin
      for (int b = a + 1; b < LANES; b++) begin
        if (wr_en[a] && wr_en[b])
          assert_lane_distinct_R6: assert (wr_idx[a*IW +: IW] != wr_idx[b*IW +: IW]);
      end
    end
  end
endmodule

// File: rtl/falloc_alarm.sv
module falloc_alarm #(
  parameter int CW      = 25,
  parameter int NUM_THR = 2
) (
  input  logic                  clk,
  input  logic [CW-1:0]         total,
  input  logic [CW-1:0]         free_d,
  input  logic [NUM_THR*CW-1:0] thr,
  output logic [NUM_THR-1:0]    alarm
);
  logic [CW-1:0] used_d;
  assign used_d = total - free_d;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    always_ff @(posedge clk) alarm[t] <= used_d > thr[t*CW +: CW];
  end
endmodule

// File: rtl/free_list_alloc.sv
module free_list_alloc
  import falloc_pkg::*;
#(
  parameter int PTR_W   = 24,
  parameter int SLOTS   = 63,
  parameter int LANES   = 4,
  parameter int NUM_THR = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [PTR_W-1:0]                      cfg_head,
  input  logic [PTR_W:0]                        cfg_nodes,
  input  logic [PTR_W-1:0]                      cfg_lo,
  input  logic [PTR_W-1:0]                      cfg_hi,
  input  logic [NUM_THR*(PTR_W+1)-1:0]          thr,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_free,
  input  logic [$clog2(LANES)-1:0]              req_num,
  input  logic [PTR_W-1:0]                      req_ptr,
  output logic                                  rsp_valid,
  output logic                                  rsp_err,
  output logic [LANES*PTR_W-1:0]                rsp_ptrs,
  output logic [PTR_W:0]                        free_count,
  output logic [NUM_THR-1:0]                    alarm,
  output logic                                  rd_fault,
  output logic                                  mem_req,
  output logic                                  mem_we,
  output logic [PTR_W+$clog2((SLOTS+1)/LANES)-1:0] mem_addr,
  output logic [LANES*ENT_W-1:0]                mem_wdata,
  input  logic                                  mem_ready,
  input  logic                                  mem_rvalid,
  input  logic [LANES*ENT_W-1:0]                mem_rdata
);
  localparam int ENTRIES = SLOTS + 1;
  localparam int DEPTH   = 2 * ENTRIES;
  localparam int IW      = $clog2(DEPTH);
  localparam int CW      = PTR_W + 1;
  localparam int WORDS   = ENTRIES / LANES;
  localparam int WIW     = $clog2(WORDS);

  function automatic logic in_rng(input logic [PTR_W-1:0] p, input logic [PTR_W-1:0] lo,
                                  input logic [PTR_W-1:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  fl_state_t      st;
  logic [IW-1:0]  bot, top, nb;
  logic [IW:0]    cnt;
  logic [PTR_W-1:0] head_q, node_q, next_ptr;
  logic [CW-1:0]  nodes_q, free_q, free_nx, free_d, total, nreq;
  logic [WIW-1:0] wcnt;
  logic           need_fill, need_spill, accept, alloc_ok, free_ok, last_w, fill_hit;
  logic [LANES-1:0]       wr_en, fault;
  logic [LANES*IW-1:0]    wr_idx, rd_idx;
  logic [LANES*PTR_W-1:0] wr_data, rd_data;

  assign top        = bot + IW'(cnt);
  assign nb         = bot - IW'(ENTRIES);
  assign need_fill  = (cnt < (IW+1)'(LANES)) && (nodes_q != '0);
  assign need_spill = (cnt == (IW+1)'(DEPTH));
  assign req_ready  = (st == ST_IDLE) && !need_fill && !need_spill;
  assign accept     = req_valid && req_ready;
  assign nreq       = CW'(req_num) + CW'(1);
  assign alloc_ok   = accept && !req_free && (free_q >= nreq);
  assign free_ok    = accept && req_free && in_rng(req_ptr, cfg_lo, cfg_hi);
  assign last_w     = (wcnt == WIW'(WORDS - 1));
  assign fill_hit   = (st == ST_FILL_WAIT) && mem_rvalid;
  assign next_ptr   = mem_rdata[(LANES-1)*ENT_W +: PTR_W];

  assign mem_req  = (st == ST_FILL_REQ) || (st == ST_SPILL);
  assign mem_we   = (st == ST_SPILL);
  assign mem_addr = {(st == ST_SPILL) ? node_q : head_q, wcnt};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ENT_W-1:0] ent;
    logic [PTR_W-1:0] eptr, sptr;
    int               j;
    assign ent  = mem_rdata[i*ENT_W +: ENT_W];
    assign eptr = ent[PTR_W-1:0];

    always_comb begin
      j = int'(wcnt) * LANES + i;
      // ring read index: stack top for allocation, window above bottom for spill
      if (st == ST_IDLE)
        rd_idx[i*IW +: IW] = (i == 0 && need_spill) ? bot : top - IW'(1 + i);
      else
        rd_idx[i*IW +: IW] = bot + IW'(j + 1);
      // ring write: one free push, or a fetched word placed below the bottom
      wr_en[i]                   = 1'b0;
      wr_idx[i*IW +: IW]         = top;
      wr_data[i*PTR_W +: PTR_W]  = req_ptr;
      if (i == 0 && free_ok) begin
        wr_en[i] = 1'b1;
      end else if (fill_hit && j < SLOTS) begin
        wr_en[i]                  = 1'b1;
        wr_idx[i*IW +: IW]        = nb + IW'(j + 1);
        wr_data[i*PTR_W +: PTR_W] = eptr;
      end else if (fill_hit) begin
        wr_en[i]                  = 1'b1;
        wr_idx[i*IW +: IW]        = nb;
        wr_data[i*PTR_W +: PTR_W] = head_q;
      end
      // integrity of a fetched entry
      fault[i] = fill_hit && ((^eptr) != ent[PTR_W] || ent[ENT_W-1:PTR_W+1] != '0 ||
                 ((j < SLOTS || nodes_q > CW'(1)) && !in_rng(eptr, cfg_lo, cfg_hi)));
      // spill word lane
      sptr = (j < SLOTS) ? rd_data[i*PTR_W +: PTR_W] : head_q;
      mem_wdata[i*ENT_W +: ENT_W] = {{(ENT_W-PTR_W-1){1'b0}}, ^sptr, sptr};
    end
  end

  falloc_ring #(.PTR_W(PTR_W), .DEPTH(DEPTH), .LANES(LANES)) ring_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_comb begin
    free_nx = free_q;
    if (alloc_ok)     free_nx = free_q - nreq;
    else if (free_ok) free_nx = free_q + CW'(1);
  end
  assign free_d = rst ? CW'(cfg_nodes * CW'(ENTRIES)) : free_nx;
  assign total  = CW'(cfg_hi) - CW'(cfg_lo) + CW'(1);

  always_ff @(posedge clk) free_q <= free_d;
  assign free_count = free_q;

  falloc_alarm #(.CW(CW), .NUM_THR(NUM_THR)) alarm_i (
    .clk(clk), .total(total), .free_d(free_d), .thr(thr), .alarm(alarm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bot       <= '0;
      cnt       <= '0;
      head_q    <= cfg_head;
      nodes_q   <= cfg_nodes;
      node_q    <= '0;
      wcnt      <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_ptrs  <= '0;
      rd_fault  <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept && !alloc_ok && !free_ok;
      rd_fault  <= |fault;
      for (int i = 0; i < LANES; i++)
        rsp_ptrs[i*PTR_W +: PTR_W] <= (alloc_ok && CW'(i) < nreq) ? rd_data[i*PTR_W +: PTR_W] : '0;
      unique case (st)
        ST_IDLE: begin
          wcnt <= '0;
          if (need_spill) begin
            node_q <= rd_data[PTR_W-1:0];
            st     <= ST_SPILL;
          end else if (need_fill) begin
            st <= ST_FILL_REQ;
          end else if (alloc_ok) begin
            cnt <= cnt - (IW+1)'(nreq);
          end else if (free_ok) begin
            cnt <= cnt + (IW+1)'(1);
          end
        end
        ST_FILL_REQ: if (mem_ready) st <= ST_FILL_WAIT;
        ST_FILL_WAIT: begin
          if (mem_rvalid) begin
            if (last_w) begin
              bot     <= nb;
              cnt     <= cnt + (IW+1)'(ENTRIES);
              head_q  <= next_ptr;
              nodes_q <= nodes_q - CW'(1);
              st      <= ST_IDLE;
            end else begin
              wcnt <= wcnt + WIW'(1);
              st   <= ST_FILL_REQ;
            end
          end
        end
        ST_SPILL: begin
          if (mem_ready) begin
            if (last_w) begin
              bot     <= bot + IW'(ENTRIES);
              cnt     <= cnt - (IW+1)'(ENTRIES);
              head_q  <= node_q;
              nodes_q <= nodes_q + CW'(1);
              st      <= ST_IDLE;
            end else begin
              wcnt <= wcnt + WIW'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // a pending memory request keeps its address, direction and data (R11)
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // no client request is taken while the list is being moved (R6)
  assert_busy_no_ready_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // free count moves only on an accepted request (R8)
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> $stable(free_count));

  // every accepted request is answered on the next cycle, and only then (R2)
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
  assert_rsp_only_R2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  // an allocation beyond the pool is refused (R5)
  assert_short_refused_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_free && nreq > free_count) |=> (rsp_err && $stable(free_count)));
endmodule

// File: tb/free_list_alloc_tb.sv
module free_list_alloc_tb_top;
  localparam int PW = 24;
  localparam int CW = 25;
  localparam logic [PW-1:0] LO = 24'h100;
  localparam logic [PW-1:0] HI = 24'h1FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           req_valid = 1'b0, req_free = 1'b0;
  logic [1:0]     req_num = '0;
  logic [PW-1:0]  req_ptr = '0;
  logic           req_ready, rsp_valid, rsp_err, rd_fault, mem_req, mem_we;
  logic [95:0]    rsp_ptrs;
  logic [CW-1:0]  free_count;
  logic [1:0]     alarm;
  logic [27:0]    mem_addr;
  logic [127:0]   mem_wdata;
  logic           mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [127:0]   mem_rdata = '0;
  logic [2*CW-1:0] thr;
  assign thr = {CW'(200), CW'(100)};

  free_list_alloc dut_i (
    .clk(clk), .rst(rst), .cfg_head(24'h100), .cfg_nodes(CW'(2)), .cfg_lo(LO), .cfg_hi(HI),
    .thr(thr), .req_valid(req_valid), .req_ready(req_ready), .req_free(req_free),
    .req_num(req_num), .req_ptr(req_ptr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_ptrs(rsp_ptrs), .free_count(free_count), .alarm(alarm), .rd_fault(rd_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;
  logic [PW-1:0] q[$];      // free pool, bottom first
  logic [PW-1:0] held[$];   // sectors handed out
  logic [127:0] mem_model [int];
  int faults = 0, reads = 0, writes = 0;
  bit checking = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ent(input logic [PW-1:0] p);
    return {7'b0, ^p, p};
  endfunction

  // memory model: random acceptance, read data one cycle after acceptance
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready  <= lfsr[0] | lfsr[2];
    mem_rvalid <= 1'b0;
    if (!rst && mem_req && mem_ready) begin
      if (mem_we) begin
        writes++;
        for (int k = 0; k < 4; k++) begin
          logic [31:0] e;
          e = mem_wdata[32*k +: 32];
          // R7 entry format of a spilled node
          chk(e[31:25] == 0 && e[24] == ^e[23:0], "R7 entry format", e, mk_ent(e[23:0]));
        end
        mem_model[int'(mem_addr)] = mem_wdata;
      end else begin
        reads++;
        mem_rdata  <= mem_model[int'(mem_addr)];
        mem_rvalid <= 1'b1;
      end
    end
    if (!rst && rd_fault) faults++;
  end

  // per-cycle comparison of count and alarms with the model (R8, R9)
  always @(negedge clk) begin
    if (checking) begin
      int used;
      used = 256 - q.size();
      chk(free_count == CW'(q.size()), "R8 free_count", free_count, q.size());
      chk(alarm == {used > 200, used > 100}, "R9 alarm", alarm, {used > 200, used > 100});
    end
  end

  task automatic do_req(input bit fr, input int n, input logic [PW-1:0] p, input string tag);
    bit exp_err;
    logic [PW-1:0] exp[4];
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_free = fr; req_num = 2'(n - 1); req_ptr = p;
    @(posedge clk);
    exp_err = 0;
    if (fr) begin
      if (p >= LO && p <= HI) q.push_back(p);
      else exp_err = 1;
    end else if (n > q.size()) begin
      exp_err = 1;
    end else begin
      for (int i = 0; i < n; i++) exp[i] = q.pop_back();
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, tag, rsp_valid, 1);
    chk(rsp_err == exp_err, tag, rsp_err, exp_err);
    if (!fr && !exp_err) begin
      for (int i = 0; i < n; i++) begin
        chk(rsp_ptrs[24*i +: 24] == exp[i], tag, rsp_ptrs[24*i +: 24], exp[i]);
        held.push_back(rsp_ptrs[24*i +: 24]);
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    // two nodes in memory: head 0x100 -> 0x140
    for (int k = 0; k < 2; k++) begin
      logic [PW-1:0] a;
      a = PW'(24'h100 + 64 * k);
      for (int w = 0; w < 16; w++) begin
        logic [127:0] wd;
        for (int l = 0; l < 4; l++) begin
          int e;
          logic [PW-1:0] p;
          e = 4 * w + l;
          p = (e < 63) ? PW'(a + PW'(e + 1)) : ((k == 0) ? 24'h140 : 24'h0);
          wd[32*l +: 32] = mk_ent(p);
        end
        if (k == 1 && w == 3) wd[24] = ~wd[24];   // corrupted parity, R10
        mem_model[int'({a, 4'(w)})] = wd;
      end
    end
    for (int k = 1; k >= 0; k--) begin
      logic [PW-1:0] a;
      a = PW'(24'h100 + 64 * k);
      q.push_back(a);
      for (int e = 0; e < 63; e++) q.push_back(PW'(a + PW'(e + 1)));
    end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(free_count == CW'(128), "R1 free_count", free_count, 128);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(req_ready == 1'b0, "R1 req_ready", req_ready, 0);
    chk(alarm == 2'b01, "R1 alarm", alarm, 1);
    checking = 1;

    // R2 allocation sizes 1..4, LIFO order
    do_req(0, 1, '0, "R2 alloc1");
    do_req(0, 2, '0, "R2 alloc2");
    do_req(0, 3, '0, "R2 alloc3");
    do_req(0, 4, '0, "R2 alloc4");
    // R4 out-of-range frees
    do_req(1, 1, 24'h050, "R4 free low");
    do_req(1, 1, 24'h300, "R4 free high");
    // R3 freed sector comes back first
    do_req(1, 1, 24'h1FF, "R3 free");
    do_req(0, 1, '0, "R3 realloc");
    do_req(1, 1, 24'h1FF, "R3 free again");
    // drain the pool across a refill (R6)
    while (q.size() >= 4) do_req(0, 4, '0, "R6 drain");
    do_req(0, 4, '0, "R5 short alloc");
    if (q.size() > 0) do_req(0, q.size(), '0, "R6 drain tail");
    do_req(0, 1, '0, "R5 empty alloc");
    chk(faults > 0, "R10 parity fault", faults, 1);
    chk(reads == 32, "R6 fill reads", reads, 32);

    // return every sector: forces a spill (R7), then take all back through a refill
    begin
      int f0;
      f0 = faults;
      while (held.size() > 0) do_req(1, 1, held.pop_front(), "R3 free back");
      chk(writes == 16, "R7 spill writes", writes, 16);
      while (q.size() >= 4) do_req(0, 4, '0, "R7 realloc");
      if (q.size() > 0) do_req(0, q.size(), '0, "R7 realloc tail");
      chk(reads == 48, "R6 refill reads", reads, 48);
      chk(faults == f0, "R10 no fault on clean node", faults, f0);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule